// File: doc/BRIEF.md
# Multi-Mode Serial Baud Clock Generator

This block produces the timing strobes for a serial port. The port runs either as an asynchronous receiver and transmitter or as a synchronous master that drives its own shift clock. A free-running counter is reloaded from a divisor `n`. Three mode pins choose one of three overall division ratios: 64, 16 or 4 clocks of `(n+1)` per bit. The block gives out three single-cycle strobes. The oversample strobe paces bit sampling. The bit strobe marks each bit boundary. The shift-clock enable is the bit strobe, gated to synchronous mode.

The divisor is loaded one byte at a time through two write strobes that share one data bus. Any write restarts the whole timing chain, so the new rate takes effect at once. The raw receive pin passes through a two-stage synchronizer. Three samples taken near the middle of each bit are then resolved by majority vote. The vote result is a strobe-qualified output: `rx_valid` acts as a valid with no ready. The samples come from a live line and cannot be held, so there is no back-pressure, and a consumer must take `rx_bit` in the cycle `rx_valid` is high.

Control pins (`enable`, the mode pins and the divisor writes) are plain levels or strobes sampled on every rising clock edge.

Top module: `baud_gen`

## Requirements
- R1: With `wide_mode` low, only the low divisor byte forms `n`, and the high byte is ignored. With `wide_mode` high, `n` is `{high byte, low byte}`. The divisor bytes reset to 0.
- R2: Asynchronous mode (`sync_mode`=0) with `wide_mode`=0 and `fast_mode`=0 gives an oversample strobe every 4(n+1) cycles and a bit strobe every 64(n+1) cycles. With n=25 the bit period is 1664 cycles, which is 9615 baud from 16 MHz.
- R3: Asynchronous mode with `wide_mode`=0 and `fast_mode`=1 gives an oversample strobe every (n+1) cycles and a bit strobe every 16(n+1) cycles.
- R4: Asynchronous mode with `wide_mode`=1 and `fast_mode`=0 gives an oversample strobe every (n+1) cycles and a bit strobe every 16(n+1) cycles.
- R5: Asynchronous mode with `wide_mode`=1 and `fast_mode`=1 gives an oversample strobe every (n+1) cycles and a bit strobe every 4(n+1) cycles.
- R6: With `sync_mode`=1, `fast_mode` has no effect. The oversample strobe comes every (n+1) cycles and the bit strobe every 4(n+1) cycles. `sclk_en` is high exactly when `baud_tick` is high in synchronous mode, and it is never high in asynchronous mode.
- R7: `baud_tick` is only ever high together with `os_tick`. At most 16 oversample strobes fall in one bit.
- R8: While `enable` is low, all counters are held cleared and no strobe is produced. If `enable` rises so that cycle E is its first high cycle, the first oversample strobe is in cycle E+P-1 and the first bit strobe in cycle E+B-1, where P and B are the oversample and bit periods. After reset, all strobes are low and `rx_bit` is 1.
- R9: A write to either divisor byte (`div_wr_lo` or `div_wr_hi`) in cycle W produces no strobe in cycle W and restarts the timing. The first oversample strobe is in cycle W+P and the first bit strobe in cycle W+B. For a high-byte write then a low-byte write in consecutive cycles, W is the cycle of the low-byte write.
- R10: Oversample strobes are numbered 1 upward from each bit boundary or restart. In the 16-per-bit modes the receive line is sampled on strobes 7, 8 and 9. In the 4-per-bit modes it is sampled on strobes 2, 3 and 4. Each sample is the `rx_pin` level two cycles before the strobe cycle. In the cycle after the third sample, `rx_valid` is high for one cycle and `rx_bit` shows the majority of the three samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low holds all counters cleared |
| sync_mode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| wide_mode | input | 1 | 1 = 16-bit divisor, 0 = low byte only |
| fast_mode | input | 1 | High-speed prescale select (asynchronous only) |
| div_wr_lo | input | 1 | Write strobe for the low divisor byte |
| div_wr_hi | input | 1 | Write strobe for the high divisor byte |
| div_wdata | input | 8 | Divisor byte to write |
| rx_pin | input | 1 | Raw asynchronous receive line |
| os_tick | output | 1 | Oversample strobe, one cycle |
| baud_tick | output | 1 | Bit boundary strobe, one cycle |
| sclk_en | output | 1 | Shift-clock enable for synchronous master mode |
| rx_bit | output | 1 | Majority-voted receive bit |
| rx_valid | output | 1 | One-cycle qualifier for `rx_bit` |

## Verification
The assertions watch, on every cycle, the relations that need no knowledge of the chosen rate. These are: the bit strobe falls only on an oversample strobe, `sclk_en` is gated by mode, the strobes are silent while disabled and in a write cycle, no strobe follows a write too early, at most 16 oversample strobes fall per bit, and a vote result appears only right after an oversample strobe. The exact periods for each mode combination only show up in the bench's scenarios. So do the divisor byte selection, the first-strobe cycle after enable rises or after a mid-period write of either byte, and the majority result for mixed sample patterns. The bench compares every strobe against a queue of predicted cycle numbers.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Overall division ratio per bit, in units of (n+1) clocks
  typedef enum logic [1:0] {
    RATE_DIV64 = 2'd0,
    RATE_DIV16 = 2'd1,
    RATE_DIV4  = 2'd2
  } rate_e;

  // Mode decode: synchronous master always runs the shortest ratio and
  // ignores the high-speed select.
  function automatic rate_e pick_rate(input logic sync_m, input logic wide_m,
                                      input logic fast_m);
    rate_e r;
    if (sync_m)       r = RATE_DIV4;
    else if (!wide_m) r = fast_m ? RATE_DIV16 : RATE_DIV64;
    else              r = fast_m ? RATE_DIV4  : RATE_DIV16;
    return r;
  endfunction

endpackage

// File: rtl/baud_gen_div_reg.sv
module baud_gen_div_reg #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wide,
  output logic [DIV_W-1:0]  n_eff,
  output logic              wr_any
);

  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end
  end

  // Narrow mode zero-extends the low byte; the high byte stays stored but unused
  always_comb begin
    if (wide) n_eff = {hi_q, lo_q};
    else      n_eff = {{(DIV_W - BYTE_W){1'b0}}, lo_q};
  end

  assign wr_any = wr_lo | wr_hi;

endmodule

// File: rtl/baud_gen_timer.sv
module baud_gen_timer
  import baud_gen_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int PRE_CNT = 4,
  parameter int OS_STD  = 16,
  parameter int OS_FAST = 4,
  parameter int SLOT_W  = $clog2(OS_STD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [DIV_W-1:0]  n_eff,
  input  rate_e             rate,
  output logic              os_tick,
  output logic              baud_tick,
  output logic [SLOT_W-1:0] slot
);

  localparam int PRE_W = (PRE_CNT > 1) ? $clog2(PRE_CNT) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRE_CNT - 1);
  localparam logic [SLOT_W-1:0] SLOT_STD  = SLOT_W'(OS_STD - 1);
  localparam logic [SLOT_W-1:0] SLOT_FAST = SLOT_W'(OS_FAST - 1);

  logic [DIV_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [SLOT_W-1:0] slot_q;
  logic              base_hit;
  logic              pre_wrap;
  logic              use_pre;
  logic [SLOT_W-1:0] slot_last;

  // Base counter: counts up from 0, terminal when it reaches n.
  // The >= compare keeps it bounded if n shrinks on a mode change.
  assign base_hit = !clear && (cnt_q >= n_eff);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (base_hit) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // Extra divide-by-PRE_CNT stage, used only by the slowest ratio
  assign use_pre  = (rate == RATE_DIV64);
  assign pre_wrap = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_q <= '0;
    else if (clear)    pre_q <= '0;
    else if (base_hit) pre_q <= (pre_wrap || !use_pre) ? '0 : pre_q + 1'b1;
  end

  assign os_tick = base_hit && (!use_pre || pre_wrap);

  // Oversample slot within the bit
  assign slot_last = (rate == RATE_DIV4) ? SLOT_FAST : SLOT_STD;
  assign baud_tick = os_tick && (slot_q >= slot_last);

  always_ff @(posedge clk) begin
    if (!rst_n)         slot_q <= '0;
    else if (clear)     slot_q <= '0;
    else if (baud_tick) slot_q <= '0;
    else if (os_tick)   slot_q <= slot_q + 1'b1;
  end

  assign slot = slot_q;

endmodule

// File: rtl/baud_gen_vote.sv
module baud_gen_vote #(
  parameter int SYNC_STAGES = 2,
  parameter int OS_STD      = 16,
  parameter int OS_FAST     = 4,
  parameter int SLOT_W      = $clog2(OS_STD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rx_pin,
  input  logic              os_tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              short_bit,
  output logic              rx_bit,
  output logic              rx_valid
);

  // First sample slot (0-based) so that the three samples straddle mid-bit
  localparam logic [SLOT_W-1:0] FIRST_STD  = SLOT_W'(OS_STD / 2 - 2);
  localparam logic [SLOT_W-1:0] FIRST_FAST = SLOT_W'(OS_FAST / 2 - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic [SLOT_W-1:0]      first;
  logic                   hit_a;
  logic                   hit_b;
  logic                   hit_c;
  logic                   smp_a;
  logic                   smp_b;
  logic                   vote;

  // Synchronizer chain, idle-high line
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= 1'b1;
    else        sync_q[0] <= rx_pin;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[g] <= 1'b1;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  assign rx_s  = sync_q[SYNC_STAGES-1];
  assign first = short_bit ? FIRST_FAST : FIRST_STD;
  assign hit_a = os_tick && (slot == first);
  assign hit_b = os_tick && (slot == first + SLOT_W'(1));
  assign hit_c = os_tick && (slot == first + SLOT_W'(2));
  assign vote  = (smp_a & smp_b) | (smp_a & rx_s) | (smp_b & rx_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else begin
      if (hit_a) smp_a <= rx_s;
      if (hit_b) smp_b <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_bit   <= 1'b1;
      rx_valid <= 1'b0;
    end else if (clear) begin
      rx_valid <= 1'b0;
    end else if (hit_c) begin
      rx_bit   <= vote;
      rx_valid <= 1'b1;
    end else begin
      rx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_CNT     = 4,
  parameter int OS_STD      = 16,
  parameter int OS_FAST     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sync_mode,
  input  logic              wide_mode,
  input  logic              fast_mode,
  input  logic              div_wr_lo,
  input  logic              div_wr_hi,
  input  logic [BYTE_W-1:0] div_wdata,
  input  logic              rx_pin,
  output logic              os_tick,
  output logic              baud_tick,
  output logic              sclk_en,
  output logic              rx_bit,
  output logic              rx_valid
);

  localparam int DIV_W  = 2 * BYTE_W;
  localparam int SLOT_W = $clog2(OS_STD);

  logic [DIV_W-1:0]  n_eff;
  logic              wr_any;
  logic              clear;
  rate_e             rate;
  logic [SLOT_W-1:0] slot;

  always_comb rate = pick_rate(sync_mode, wide_mode, fast_mode);

  // A disabled block or any divisor write restarts every counter
  assign clear = !enable || wr_any;

  baud_gen_div_reg #(
    .BYTE_W (BYTE_W),
    .DIV_W  (DIV_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (div_wr_lo),
    .wr_hi  (div_wr_hi),
    .wdata  (div_wdata),
    .wide   (wide_mode),
    .n_eff  (n_eff),
    .wr_any (wr_any)
  );

  baud_gen_timer #(
    .DIV_W   (DIV_W),
    .PRE_CNT (PRE_CNT),
    .OS_STD  (OS_STD),
    .OS_FAST (OS_FAST),
    .SLOT_W  (SLOT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .n_eff     (n_eff),
    .rate      (rate),
    .os_tick   (os_tick),
    .baud_tick (baud_tick),
    .slot      (slot)
  );

  baud_gen_vote #(
    .SYNC_STAGES (SYNC_STAGES),
    .OS_STD      (OS_STD),
    .OS_FAST     (OS_FAST),
    .SLOT_W      (SLOT_W)
  ) u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .rx_pin    (rx_pin),
    .os_tick   (os_tick),
    .slot      (slot),
    .short_bit (rate == RATE_DIV4),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid)
  );

  assign sclk_en = baud_tick && sync_mode;

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             sync_mode,
  input logic             div_wr_lo,
  input logic             div_wr_hi,
  input logic [DIV_W-1:0] n_eff,
  input logic             os_tick,
  input logic             baud_tick,
  input logic             sclk_en,
  input logic             rx_valid
);

  logic [4:0] os_in_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)                               os_in_bit <= '0;
    else if (!enable || div_wr_lo || div_wr_hi) os_in_bit <= '0;
    else if (baud_tick)                       os_in_bit <= '0;
    else if (os_tick)                         os_in_bit <= os_in_bit + 1'b1;
  end

  // R7
  baud_on_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> os_tick);

  // R7
  bit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> (os_in_bit < 5'd16));

  // R6
  sclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> (sync_mode && baud_tick));

  // R6
  sclk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && baud_tick) |-> sclk_en);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!os_tick && !baud_tick && !sclk_en));

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr_lo || div_wr_hi) |-> !os_tick);

  // R9
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_wr_lo || div_wr_hi) && (n_eff != '0)) |-> !os_tick);

  // R10
  vote_after_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(os_tick));

endmodule

bind baud_gen baud_gen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .sync_mode (sync_mode),
  .div_wr_lo (div_wr_lo),
  .div_wr_hi (div_wr_hi),
  .n_eff     (n_eff),
  .os_tick   (os_tick),
  .baud_tick (baud_tick),
  .sclk_en   (sclk_en),
  .rx_valid  (rx_valid)
);

// File: tb/baud_gen_tb_top.sv
module baud_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       sync_mode = 1'b0;
  logic       wide_mode = 1'b0;
  logic       fast_mode = 1'b0;
  logic       div_wr_lo = 1'b0;
  logic       div_wr_hi = 1'b0;
  logic [7:0] div_wdata = 8'h00;
  logic       rx_pin = 1'b1;
  logic       os_tick;
  logic       baud_tick;
  logic       sclk_en;
  logic       rx_bit;
  logic       rx_valid;

  baud_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sync_mode (sync_mode),
    .wide_mode (wide_mode),
    .fast_mode (fast_mode),
    .div_wr_lo (div_wr_lo),
    .div_wr_hi (div_wr_hi),
    .div_wdata (div_wdata),
    .rx_pin    (rx_pin),
    .os_tick   (os_tick),
    .baud_tick (baud_tick),
    .sclk_en   (sclk_en),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    cyc = 0;
  int    n_checks = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  string cur_req = "R8";
  bit    os_on = 1'b0;
  bit    baud_on = 1'b0;
  bit    rx_on = 1'b0;
  bit    exp_sclk = 1'b0;
  int    os_q[$];
  int    baud_q[$];
  int    rx_cyc_q[$];
  bit    rx_val_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops predictions as strobes appear (sampled at negedge)
  always @(negedge clk) begin
    if (rst_n) begin
      if (os_on && os_tick) begin
        if (os_q.size() == 0) report(1'b0, cur_req, "oversample strobe cycle (-1 = none expected)", cyc, -1);
        else begin
          int e;
          e = os_q.pop_front();
          report(cyc == e, cur_req, "oversample strobe cycle", cyc, e);
        end
      end
      if (baud_on && baud_tick) begin
        if (baud_q.size() == 0) report(1'b0, cur_req, "bit strobe cycle (-1 = none expected)", cyc, -1);
        else begin
          int e;
          e = baud_q.pop_front();
          report(cyc == e, cur_req, "bit strobe cycle", cyc, e);
          report(sclk_en == exp_sclk, "R6", "sclk_en at bit strobe", int'(sclk_en), int'(exp_sclk));
        end
      end
      if (baud_on && sclk_en && !baud_tick)
        report(1'b0, "R6", "sclk_en without bit strobe", 1, 0);
      if (rx_on && rx_valid) begin
        if (rx_cyc_q.size() == 0) report(1'b0, "R10", "rx_valid cycle (-1 = none expected)", cyc, -1);
        else begin
          int  e;
          bit  v;
          e = rx_cyc_q.pop_front();
          v = rx_val_q.pop_front();
          report(cyc == e, "R10", "rx_valid cycle", cyc, e);
          report(rx_bit == v, "R10", "voted rx_bit", int'(rx_bit), int'(v));
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) step();
  endtask

  task automatic push_rate(input int base, input int os_p, input int baud_p);
    for (int k = 1; k <= (2 * baud_p) / os_p; k++) os_q.push_back(base + k * os_p);
    baud_q.push_back(base + baud_p);
    baud_q.push_back(base + 2 * baud_p);
  endtask

  task automatic close_window(input string req, input int end_cyc);
    wait_until(end_cyc);
    os_on = 1'b0;
    baud_on = 1'b0;
    report(os_q.size() == 0, req, "oversample strobes left unseen", os_q.size(), 0);
    report(baud_q.size() == 0, req, "bit strobes left unseen", baud_q.size(), 0);
    os_q.delete();
    baud_q.delete();
  endtask

  // wr_kind: 0 = low byte only, 1 = high byte only, 2 = high then low
  task automatic run_rate(input string req, input bit s, input bit w, input bit f,
                          input int wr_kind, input logic [7:0] hi, input logic [7:0] lo,
                          input int os_p, input int baud_p);
    int w_cyc;
    step();
    sync_mode = s;
    wide_mode = w;
    fast_mode = f;
    cur_req   = req;
    exp_sclk  = s;
    if (wr_kind == 2) begin
      div_wdata = hi;
      div_wr_hi = 1'b1;
      step();
      div_wr_hi = 1'b0;
    end
    if (wr_kind == 1) begin
      div_wdata = hi;
      div_wr_hi = 1'b1;
    end else begin
      div_wdata = lo;
      div_wr_lo = 1'b1;
    end
    w_cyc = cyc;
    push_rate(w_cyc, os_p, baud_p);
    os_on = 1'b1;
    baud_on = 1'b1;
    step();
    div_wr_lo = 1'b0;
    div_wr_hi = 1'b0;
    close_window(req, w_cyc + 2 * baud_p + 2);
  endtask

  // Majority vote: n=3 low byte, samples driven 3 cycles ahead of each strobe
  task automatic vote_case(input bit s, input bit a, input bit b, input bit c);
    int w_cyc;
    int first_os;
    bit maj;
    step();
    sync_mode = s;
    wide_mode = 1'b0;
    fast_mode = 1'b1;
    maj = (a & b) | (a & c) | (b & c);
    rx_pin = ~maj;
    div_wdata = 8'd3;
    div_wr_lo = 1'b1;
    w_cyc = cyc;
    first_os = s ? 2 : 7;
    rx_cyc_q.push_back(w_cyc + 4 * (first_os + 2) + 1);
    rx_val_q.push_back(maj);
    rx_on = 1'b1;
    step();
    div_wr_lo = 1'b0;
    wait_until(w_cyc + 4 * first_os - 3);
    rx_pin = a;
    wait_until(w_cyc + 4 * (first_os + 1) - 3);
    rx_pin = b;
    wait_until(w_cyc + 4 * (first_os + 2) - 3);
    rx_pin = c;
    wait_until(w_cyc + 4 * (first_os + 2) + 3);
    rx_on = 1'b0;
    report(rx_cyc_q.size() == 0, "R10", "vote results left unseen", rx_cyc_q.size(), 0);
    rx_cyc_q.delete();
    rx_val_q.delete();
  endtask

  initial begin
    int e1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R8 reset state
    report(os_tick == 1'b0, "R8", "os_tick after reset", int'(os_tick), 0);
    report(baud_tick == 1'b0, "R8", "baud_tick after reset", int'(baud_tick), 0);
    report(rx_valid == 1'b0, "R8", "rx_valid after reset", int'(rx_valid), 0);
    report(rx_bit == 1'b1, "R8", "rx_bit after reset", int'(rx_bit), 1);
    enable = 1'b1;
    step();

    // R2 slow narrow asynchronous, n=25: 104 / 1664 cycles
    run_rate("R2", 1'b0, 1'b0, 1'b0, 0, 8'h00, 8'd25, 104, 1664);
    // R3 with R1: high byte 1 ignored in narrow mode, n=3
    run_rate("R3", 1'b0, 1'b0, 1'b1, 2, 8'h01, 8'd3, 4, 64);

    // R8 disable, then re-enable with n=3 narrow fast
    step();
    cur_req = "R8";
    os_on = 1'b1;
    baud_on = 1'b1;
    enable = 1'b0;
    repeat (20) step();
    enable = 1'b1;
    e1 = cyc;
    push_rate(e1 - 1, 4, 64);
    close_window("R8", e1 + 2 * 64 + 2);

    // R5 with R1: full 16-bit n = 0x0103 = 259
    run_rate("R5", 1'b0, 1'b1, 1'b1, 2, 8'h01, 8'h03, 260, 1040);
    // R4 wide slow, n=5
    run_rate("R4", 1'b0, 1'b1, 1'b0, 2, 8'h00, 8'd5, 6, 96);
    // R6 synchronous, fast select low and high give the same rate
    run_rate("R6", 1'b1, 1'b0, 1'b0, 0, 8'h00, 8'd7, 8, 32);
    run_rate("R6", 1'b1, 1'b0, 1'b1, 0, 8'h00, 8'd7, 8, 32);

    // R9 mid-period restarts: high-byte write (ignored value), then low-byte write
    repeat (13) step();
    run_rate("R9", 1'b1, 1'b0, 1'b0, 1, 8'h55, 8'h00, 8, 32);
    repeat (5) step();
    run_rate("R9", 1'b1, 1'b0, 1'b1, 0, 8'h00, 8'd9, 10, 40);

    // R10 majority vote, 16-per-bit then 4-per-bit
    vote_case(1'b0, 1'b1, 1'b0, 1'b1);
    vote_case(1'b0, 1'b0, 1'b1, 1'b0);
    vote_case(1'b0, 1'b1, 1'b1, 1'b0);
    vote_case(1'b0, 1'b0, 1'b0, 1'b1);
    vote_case(1'b1, 1'b0, 1'b1, 1'b1);
    vote_case(1'b1, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule